// File: doc/BRIEF.md
# Checkpointed Register File

This block is a multi-ported register file that holds two copies of every architectural register. The working copy is the one program execution sees: reads return it and the write port updates it. The shadow copy is a checkpoint that ordinary writes cannot reach. It changes only when a commit strobe copies the whole working set into it in a single clock.

A restore strobe copies the whole shadow set back into the working copy in a single clock. A sequencer running speculatively translated code issues a commit at each block boundary. If an exception is detected part-way through a block, the sequencer issues a restore, which rolls the register state back to the last commit point so the block can be re-run another way. The block only reacts to the two strobes; it has no logic of its own that decides when to checkpoint or roll back.

The number of registers, the data width and the number of read ports are parameters. Parameter values are checked during elaboration.

Top module: `shadow_ckpt_regfile`

## Requirements
- R1: While reset is asserted, every working register and every shadow register is set to zero. Reads after reset return zero, and a restore issued with no commit since reset also yields zero.
- R2: When `wr_en` is high and no restore is asserted in that cycle, the working register selected by `wr_addr` takes `wr_data` at the clock edge. The new value is readable in the following cycle.
- R3: Each read port returns the working register selected by its own address slice. The read is combinational, and the ports are independent of each other. Port k uses `rd_addr[k*ADDR_W +: ADDR_W]` and `rd_data[k*DATA_W +: DATA_W]`.
- R4: A commit strobe copies every working register into the matching shadow register at one clock edge.
- R5: Write-port activity never changes a shadow register.
- R6: A restore strobe copies every shadow register into the matching working register at one clock edge. A read in the next cycle returns the restored value.
- R7: When commit and restore are asserted in the same cycle, the restore takes effect and the commit is ignored, so the shadow copy keeps its previous contents.
- R8: A write issued in the same cycle as a restore is discarded.
- R9: A write issued in the same cycle as a commit updates only the working copy. The shadow copy of that register receives the value it held before the write.
- R10: Repeated restores with no commit between them return the working copy to the same checkpoint each time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write enable for the working copy |
| wr_addr | input | 4 | Register index to write |
| wr_data | input | 32 | Data to write |
| chk_commit | input | 1 | Copy the working set into the shadow set |
| chk_restore | input | 1 | Copy the shadow set into the working set |
| rd_addr | input | 8 | Packed read addresses, one 4-bit slice per read port |
| rd_data | output | 32*2 = 64 | Packed read data, one 32-bit slice per read port |

## Verification
The hardest situations to reach from the ports are the collisions: a write landing in the same cycle as a commit or a restore, and both strobes arriving together. A collision leaves its mark only in the shadow copy, which cannot be read directly. The bench therefore sets up each collision deliberately, then overwrites the affected register and issues a later restore, so that the shadow contents show up on a read port. Random cycles with frequent strobes then mix these cases with ordinary traffic, and every read is compared against a two-copy model kept in the bench.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;

   // Bulk operation applied to the register array in a given cycle
   typedef enum logic [1:0] {
      CKPT_OP_IDLE    = 2'd0,
      CKPT_OP_COMMIT  = 2'd1,
      CKPT_OP_RESTORE = 2'd2
   } ckpt_op_e;

   function automatic int unsigned ckpt_addr_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/ckpt_strobe_ctrl.sv
module ckpt_strobe_ctrl
   import ckpt_pkg::*;
#(
   parameter int unsigned NUM_REGS = 16,
   parameter int unsigned ADDR_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                commit_i,
   input  logic                restore_i,
   input  logic                wr_en_i,
   input  logic [ADDR_W-1:0]   wr_addr_i,
   output ckpt_op_e            op_o,
   output logic [NUM_REGS-1:0] wr_onehot_o
);

   // Restore outranks commit; a write is dropped under restore
   always_comb begin
      if (restore_i)      op_o = CKPT_OP_RESTORE;
      else if (commit_i)  op_o = CKPT_OP_COMMIT;
      else                op_o = CKPT_OP_IDLE;
   end

   logic wr_allow;
   assign wr_allow = wr_en_i && !restore_i;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
      assign wr_onehot_o[i] = wr_allow && (wr_addr_i == ADDR_W'(i));
   end

   AST_RESTORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && restore_i) |-> (op_o == CKPT_OP_RESTORE)); // R7

   AST_WRITE_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
      restore_i |-> (wr_onehot_o == '0)); // R8

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_onehot_o)); // R2

endmodule

// File: rtl/ckpt_reg_slice.sv
module ckpt_reg_slice
   import ckpt_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ckpt_op_e          op_i,
   input  logic              wr_hit_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] work_o
);

   logic [DATA_W-1:0] work_q;
   logic [DATA_W-1:0] shadow_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         work_q   <= '0;
         shadow_q <= '0;
      end else begin
         unique case (op_i)
            CKPT_OP_RESTORE: work_q <= shadow_q;
            CKPT_OP_COMMIT: begin
               shadow_q <= work_q;
               if (wr_hit_i) work_q <= wr_data_i;
            end
            default: begin
               if (wr_hit_i) work_q <= wr_data_i;
            end
         endcase
      end
   end

   assign work_o = work_q;

   AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == CKPT_OP_COMMIT) |=> (shadow_q == $past(work_q))); // R4

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i != CKPT_OP_COMMIT) |=> $stable(shadow_q)); // R5

   AST_RESTORE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == CKPT_OP_RESTORE) |=> (work_q == $past(shadow_q))); // R6

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit_i |=> (work_q == $past(wr_data_i))); // R2

endmodule

// File: rtl/ckpt_read_port.sv
module ckpt_read_port #(
   parameter int unsigned NUM_REGS = 16,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 4
) (
   input  logic [DATA_W-1:0] regs_i [NUM_REGS],
   input  logic [ADDR_W-1:0] addr_i,
   output logic [DATA_W-1:0] data_o
);

   localparam bit FULL_MAP = ((1 << ADDR_W) == NUM_REGS);

   if (FULL_MAP) begin : g_direct
      // Every address maps to a register: plain index
      assign data_o = regs_i[addr_i];
   end else begin : g_guarded
      // Unmapped addresses read as zero
      always_comb begin
         data_o = '0;
         for (int i = 0; i < NUM_REGS; i++) begin
            if (addr_i == ADDR_W'(i)) data_o = regs_i[i];
         end
      end
   end

endmodule

// File: rtl/shadow_ckpt_regfile.sv
module shadow_ckpt_regfile
   import ckpt_pkg::*;
#(
   parameter int unsigned NUM_REGS = 16,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_RD   = 2,
   localparam int unsigned ADDR_W  = ckpt_addr_bits(NUM_REGS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     chk_commit,
   input  logic                     chk_restore,
   input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
   output logic [NUM_RD*DATA_W-1:0] rd_data
);

   if (NUM_REGS < 2) begin : g_bad_regs
      $error("shadow_ckpt_regfile: NUM_REGS must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("shadow_ckpt_regfile: DATA_W must be at least 1");
   end
   if (NUM_RD < 1 || NUM_RD > 8) begin : g_bad_rd
      $error("shadow_ckpt_regfile: NUM_RD must lie in 1..8");
   end

   ckpt_op_e            op;
   logic [NUM_REGS-1:0] wr_onehot;
   logic [DATA_W-1:0]   work_vals [NUM_REGS];

   ckpt_strobe_ctrl #(
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit_i    (chk_commit),
      .restore_i   (chk_restore),
      .wr_en_i     (wr_en),
      .wr_addr_i   (wr_addr),
      .op_o        (op),
      .wr_onehot_o (wr_onehot)
   );

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      ckpt_reg_slice #(
         .DATA_W (DATA_W)
      ) u_slice (
         .clk       (clk),
         .rst_n     (rst_n),
         .op_i      (op),
         .wr_hit_i  (wr_onehot[r]),
         .wr_data_i (wr_data),
         .work_o    (work_vals[r])
      );
   end

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      ckpt_read_port #(
         .NUM_REGS (NUM_REGS),
         .DATA_W   (DATA_W),
         .ADDR_W   (ADDR_W)
      ) u_port (
         .regs_i (work_vals),
         .addr_i (rd_addr[p*ADDR_W +: ADDR_W]),
         .data_o (rd_data[p*DATA_W +: DATA_W])
      );
   end

   AST_RESTORE_IDLE_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_restore && wr_en) |-> (op == CKPT_OP_RESTORE && wr_onehot == '0)); // R8

endmodule

// File: tb/shadow_ckpt_regfile_test.sv
module shadow_ckpt_regfile_test;

   localparam int NR = 16;
   localparam int DW = 32;
   localparam int AW = 4;
   localparam int NP = 2;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            wr_en;
   logic [AW-1:0]   wr_addr;
   logic [DW-1:0]   wr_data;
   logic            chk_commit;
   logic            chk_restore;
   logic [NP*AW-1:0] rd_addr;
   logic [NP*DW-1:0] rd_data;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   logic [DW-1:0] work_m [NR];
   logic [DW-1:0] shad_m [NR];

   always #10 clk = ~clk; // 50 MHz

   shadow_ckpt_regfile #(.NUM_REGS(NR), .DATA_W(DW), .NUM_RD(NP)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .chk_commit(chk_commit), .chk_restore(chk_restore),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // Expected next state of the two copies, taken from the requirements
   function automatic void model_step(bit we, int wa, logic [DW-1:0] wd, bit cm, bit rs);
      if (rs) begin
         for (int i = 0; i < NR; i++) work_m[i] = shad_m[i];
      end else begin
         if (cm) for (int i = 0; i < NR; i++) shad_m[i] = work_m[i];
         if (we) work_m[wa] = wd;
      end
   endfunction

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(bit we, int wa, logic [DW-1:0] wd, bit cm, bit rs);
      @(negedge clk);
      wr_en = we; wr_addr = AW'(wa); wr_data = wd;
      chk_commit = cm; chk_restore = rs;
      @(posedge clk);
      model_step(we, wa, wd, cm, rs);
   endtask

   task automatic peek(string req, int r, logic [DW-1:0] exp);
      @(negedge clk);
      wr_en = 0; chk_commit = 0; chk_restore = 0;
      rd_addr[AW-1:0] = AW'(r);
      #2;
      chk(req, rd_data[DW-1:0], exp);
   endtask

   task automatic peek2(string req, int r0, int r1, logic [DW-1:0] e0, logic [DW-1:0] e1);
      @(negedge clk);
      wr_en = 0; chk_commit = 0; chk_restore = 0;
      rd_addr = {AW'(r1), AW'(r0)};
      #2;
      chk(req, rd_data[DW-1:0], e0);
      chk(req, rd_data[2*DW-1:DW], e1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
      chk_commit = 0; chk_restore = 0; rd_addr = '0;
      for (int i = 0; i < NR; i++) begin work_m[i] = '0; shad_m[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R1: all working registers zero, shadow zero via restore
      for (int i = 0; i < NR; i++) peek("R1 reset", i, 32'h0);
      cyc(1, 7, 32'hDEAD_BEEF, 0, 0);
      cyc(0, 0, 0, 0, 1);
      peek("R1 shadow cleared", 7, 32'h0);

      // R2: write then read
      cyc(1, 3, 32'hA1A1_0003, 0, 0);
      peek("R2 write", 3, 32'hA1A1_0003);

      // R3: two ports, different registers
      cyc(1, 4, 32'hB2B2_0004, 0, 0);
      peek2("R3 dual read", 3, 4, 32'hA1A1_0003, 32'hB2B2_0004);

      // R4/R5/R6: checkpoint, overwrite, roll back
      for (int i = 0; i < NR; i++) cyc(1, i, 32'(1000 + i), 0, 0);
      cyc(0, 0, 0, 1, 0);
      for (int i = 0; i < NR; i++) cyc(1, i, 32'(2000 + i), 0, 0);
      peek("R5 working updated", 5, 32'd2005);
      cyc(0, 0, 0, 0, 1);
      peek("R6 read after restore", 5, 32'd1005);
      for (int i = 0; i < NR; i++) peek("R4 full checkpoint", i, 32'(1000 + i));

      // R7: both strobes: restore wins, shadow untouched
      cyc(1, 2, 32'd3333, 0, 0);
      cyc(0, 0, 0, 1, 1);
      peek("R7 restore wins", 2, 32'd1002);
      cyc(1, 2, 32'd4444, 0, 0);
      cyc(0, 0, 0, 0, 1);
      peek("R7 commit ignored", 2, 32'd1002);

      // R8: write under restore discarded
      cyc(1, 6, 32'd5555, 0, 1);
      peek("R8 write dropped", 6, 32'd1006);

      // R9: write under commit reaches working copy only
      cyc(1, 9, 32'd6666, 1, 0);
      peek("R9 working gets write", 9, 32'd6666);
      cyc(1, 9, 32'd7777, 0, 0);
      cyc(0, 0, 0, 0, 1);
      peek("R9 shadow has prior value", 9, 32'd1009);

      // R10: repeated restore without commit
      cyc(1, 1, 32'd8888, 0, 0);
      cyc(0, 0, 0, 0, 1);
      peek("R10 first restore", 1, 32'd1001);
      cyc(1, 1, 32'd9999, 0, 0);
      cyc(0, 0, 0, 0, 1);
      peek("R10 second restore", 1, 32'd1001);

      // Random traffic against the model
      for (int n = 0; n < 3000; n++) begin
         bit we, cm, rs;
         int wa, r0, r1;
         logic [DW-1:0] wd;
         we = ($urandom % 4) != 0;
         cm = ($urandom % 6) == 0;
         rs = ($urandom % 8) == 0;
         wa = int'($urandom % NR);
         wd = $urandom;
         cyc(we, wa, wd, cm, rs);
         r0 = int'($urandom % NR);
         r1 = int'($urandom % NR);
         peek2("R3 random read", r0, r1, work_m[r0], work_m[r1]);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule